// File: doc/BRIEF.md
# RF Collision Avoidance Mode Controller

This block decides whether a peer-to-peer near-field device behaves as a listening target or as an initiator, and when its own carrier may be switched on. Out of reset the device listens with its field off. An application asks for initiator mode through a request line. The controller then watches the external-field detector and switches its own field on only after the detector has stayed quiet for a programmable number of consecutive cycles. A detection during that window starts the count again from zero.

When the field comes on, the controller pulses an initialisation start for one cycle and latches the requested transfer rate. That rate is held fixed for the whole transaction. A transaction-end indication switches the field off and returns the device to target mode. Requests that arrive while a transaction runs are only served after it has ended. The field-detect input passes through a configurable synchronizer chain (0 to 4 stages) before it is used.

Top module: `rf_collision_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rf_on_o, initiator_o and init_start_o are 0 and rate_o is 0.
- R2: Without init_req_i the field stays off and initiator_o stays 0, whatever ext_field_i does.
- R3: With init_req_i held, the field turns on only after idle_cycles_i consecutive edges during listening at which the synchronised detect is low. Each high detect restarts the count at zero. ext_field_i reaches the decision SYNC_STAGES edges after it is sampled.
- R4: An idle_cycles_i value of 0 behaves exactly like 1.
- R5: init_start_o is high for exactly one cycle, which is the first cycle in which rf_on_o is high.
- R6: rate_o takes the rate_sel_i value sampled at the edge where the field turns on. It ignores every later change of rate_sel_i until a new transaction starts.
- R7: txn_end_i while the field is on turns rf_on_o and initiator_o off at the next edge. txn_end_i in any other phase has no effect.
- R8: Dropping init_req_i during the listen window returns the block to target mode at the next edge with the field off. The partial count is discarded.
- R9: A request held through a transaction is not served during it. After the end there is one target cycle, and then a fresh full window.
- R10: initiator_o is 1 from the edge after a request is accepted until the transaction ends or the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_field_i | input | 1 | External RF field detected (asynchronous) |
| init_req_i | input | 1 | Application asks for initiator mode |
| txn_end_i | input | 1 | Current transaction is complete |
| idle_cycles_i | input | CNT_W | Required field-free window in cycles |
| rate_sel_i | input | RATE_W | Requested transfer rate code |
| rf_on_o | output | 1 | Own RF field enable |
| initiator_o | output | 1 | 1 = initiator role, 0 = target |
| init_start_o | output | 1 | One-cycle start of initialisation |
| rate_o | output | RATE_W | Transfer rate locked for the transaction |

## Verification
A wrong mode state shows up at once as a mismatch on rf_on_o or initiator_o in the very next cycle, because both are decoded straight from the state register. A corrupted idle counter shows only when the field turns on, one or more cycles early or late relative to the last detected field. It is therefore checked on windows with restarts at several positions and with a zero setting. A faulty rate latch shows as rate_o moving while the field is on, at any cycle of the transaction after rate_sel_i changes.

// File: rtl/rfca_pkg.sv
package rfca_pkg;
   typedef enum logic [1:0] {
      RFCA_TARGET = 2'd0,
      RFCA_LISTEN = 2'd1,
      RFCA_OWNER  = 2'd2
   } rfca_state_e;
endpackage

// File: rtl/rfca_detect_sync.sv
module rfca_detect_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (STAGES == 1) sh_q <= d_i;
            else sh_q <= {sh_q[STAGES-2+(STAGES==1):0], d_i};
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rfca_quiet_timer.sv
module rfca_quiet_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             field_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);
   localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W:0]   limit_eff;

   assign limit_eff = (limit_i == '0) ? ONE : {1'b0, limit_i};
   assign cnt_inc   = {1'b0, cnt_q} + ONE;
   assign done_o    = run_i && !field_i && (cnt_inc >= limit_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!run_i || field_i || done_o) cnt_q <= '0;
      else                               cnt_q <= cnt_inc[CNT_W-1:0];
   end
endmodule

// File: rtl/rfca_rate_hold.sv
module rfca_rate_hold #(
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic [RATE_W-1:0] rate_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rate_o <= '0;
      else if (load_i) rate_o <= rate_i;
   end
endmodule

// File: rtl/rf_collision_ctrl.sv
module rf_collision_ctrl
   import rfca_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int RATE_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_field_i,
   input  logic              init_req_i,
   input  logic              txn_end_i,
   input  logic [CNT_W-1:0]  idle_cycles_i,
   input  logic [RATE_W-1:0] rate_sel_i,
   output logic              rf_on_o,
   output logic              initiator_o,
   output logic              init_start_o,
   output logic [RATE_W-1:0] rate_o
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
      if (RATE_W < 1) begin : g_bad_rate
         $error("RATE_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   rfca_state_e st_q, st_d;
   logic        field_s;
   logic        window_done;
   logic        go_owner;
   logic        start_q;

   rfca_detect_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_field_i),
      .q_o   (field_s)
   );

   rfca_quiet_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (st_q == RFCA_LISTEN),
      .field_i (field_s),
      .limit_i (idle_cycles_i),
      .done_o  (window_done)
   );

   always_comb begin
      st_d     = st_q;
      go_owner = 1'b0;
      unique case (st_q)
         RFCA_TARGET: if (init_req_i) st_d = RFCA_LISTEN;
         RFCA_LISTEN: begin
            if (!init_req_i) st_d = RFCA_TARGET;
            else if (window_done) begin
               st_d     = RFCA_OWNER;
               go_owner = 1'b1;
            end
         end
         RFCA_OWNER:  if (txn_end_i) st_d = RFCA_TARGET;
         default:     st_d = RFCA_TARGET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RFCA_TARGET;
         start_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         start_q <= go_owner;
      end
   end

   rfca_rate_hold #(.RATE_W(RATE_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (go_owner),
      .rate_i (rate_sel_i),
      .rate_o (rate_o)
   );

   assign rf_on_o      = (st_q == RFCA_OWNER);
   assign initiator_o  = (st_q != RFCA_TARGET);
   assign init_start_o = start_q;
endmodule

// File: rtl/rfca_checker.sv
module rfca_checker #(
   parameter int CNT_W  = 16,
   parameter int RATE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txn_end_i,
   input logic [CNT_W-1:0]  idle_cycles_i,
   input logic              rf_on_o,
   input logic              initiator_o,
   input logic              init_start_o,
   input logic [RATE_W-1:0] rate_o
);
   logic [CNT_W:0] listen_len;
   logic [CNT_W:0] need_len;

   assign need_len = (idle_cycles_i == '0) ? (CNT_W+1)'(1) : {1'b0, idle_cycles_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) listen_len <= '0;
      else if (!initiator_o || rf_on_o) listen_len <= '0;
      else if (listen_len != '1) listen_len <= listen_len + 1'b1;
   end

   // R10: own field only in initiator role
   a_r10_field_implies_initiator: assert property (@(posedge clk) disable iff (!rst_n)
      rf_on_o |-> initiator_o);

   // R5: start coincides with first field cycle
   a_r5_start_with_field: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_on_o) |-> init_start_o);

   a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      init_start_o |=> !init_start_o);

   // R6: rate frozen while field stays on
   a_r6_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_on_o && $past(rf_on_o)) |-> $stable(rate_o));

   // R7: end of transaction drops field
   a_r7_end_drops_field: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_on_o && txn_end_i) |=> (!rf_on_o && !initiator_o));

   // R3: at least the idle window was spent listening
   a_r3_window_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_on_o) |-> (listen_len >= $past(need_len)));
endmodule

bind rf_collision_ctrl rfca_checker #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .txn_end_i     (txn_end_i),
   .idle_cycles_i (idle_cycles_i),
   .rf_on_o       (rf_on_o),
   .initiator_o   (initiator_o),
   .init_start_o  (init_start_o),
   .rate_o        (rate_o)
);

// File: tb/sim_rf_collision_ctrl.sv
module sim_rf_collision_ctrl;
   localparam int PERIOD = 10;
   localparam int CW = 16;
   localparam int RW = 2;
   localparam int SY = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_field = 1'b0;
   logic          req = 1'b0;
   logic          tend = 1'b0;
   logic [CW-1:0] idle = 16'd5;
   logic [RW-1:0] rsel = '0;
   logic          rf_on, initiator, istart;
   logic [RW-1:0] rate;

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    done = 0;

   // behavioural reference
   int m_st = 0;  // 0 target, 1 listening, 2 field owner
   int m_cnt = 0;
   int m_rate = 0;
   int m_start = 0;
   bit hist[$];

   always #(PERIOD/2) clk = ~clk;

   rf_collision_ctrl #(.CNT_W(CW), .RATE_W(RW), .SYNC_STAGES(SY)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_field_i(ext_field), .init_req_i(req),
      .txn_end_i(tend), .idle_cycles_i(idle), .rate_sel_i(rsel),
      .rf_on_o(rf_on), .initiator_o(initiator), .init_start_o(istart), .rate_o(rate));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_rate = 0; m_start = 0;
         hist = {};
         for (int i = 0; i < SY; i++) hist.push_back(1'b0);
      end else begin
         bit seen;
         int need;
         need = (idle == 0) ? 1 : int'(idle);
         if (SY == 0) seen = ext_field;
         else begin
            seen = hist.pop_front();
            hist.push_back(ext_field);
         end
         m_start = 0;
         case (m_st)
            0: if (req) begin m_st = 1; m_cnt = 0; end
            1: begin
               if (!req) m_st = 0;
               else if (seen) m_cnt = 0;
               else begin
                  m_cnt++;
                  if (m_cnt >= need) begin
                     m_st = 2; m_rate = int'(rsel); m_start = 1;
                  end
               end
            end
            default: if (tend) m_st = 0;
         endcase
      end
   end

   task automatic cmp(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (!done) begin
      cmp("rf_on (R3)", int'(rf_on), int'(m_st == 2));
      cmp("initiator (R10)", int'(initiator), int'(m_st != 0));
      cmp("init_start (R5)", int'(istart), m_start);
      cmp("rate (R6)", int'(rate), m_rate);
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int k;
      // R1: reset state
      tag = "R1";
      step(3);
      cmp("R1 rf_on in reset", int'(rf_on), 0);
      cmp("R1 rate in reset", int'(rate), 0);
      rst_n = 1'b1;
      step(2);

      // R2: field activity with no request
      tag = "R2";
      for (int i = 0; i < 20; i++) begin ext_field = i[0]; step(1); end
      ext_field = 0;
      step(4);
      cmp("R2 initiator stays low", int'(initiator), 0);

      // R7: transaction end outside a transaction does nothing
      tag = "R7";
      tend = 1; step(2); tend = 0; step(1);
      cmp("R7 idle end no effect", int'(rf_on), 0);

      // R3 / R6 / R7: window with restarts, then transaction
      tag = "R3";
      idle = 16'd5; rsel = 2'd2;
      req = 1;
      step(3);
      ext_field = 1; step(1); ext_field = 0;
      step(4);
      ext_field = 1; step(1); ext_field = 0;
      k = 0;
      while (!rf_on && k < 40) begin step(1); k++; end
      cmp("R3 field reached", int'(rf_on), 1);
      tag = "R6";
      rsel = 2'd1; step(3); rsel = 2'd3; step(3);
      cmp("R6 rate held", int'(rate), 2);
      tag = "R9";
      step(2);
      tag = "R7";
      tend = 1; step(1); tend = 0;
      cmp("R7 field off after end", int'(rf_on), 0);
      // R9: request still high, served again after a full window
      tag = "R9";
      step(1);
      cmp("R9 relisten", int'(initiator), 1);
      cmp("R9 no early field", int'(rf_on), 0);
      step(8);
      cmp("R9 field after window", int'(rf_on), 1);
      rsel = 2'd0;
      tend = 1; step(1); tend = 0; req = 0;
      step(3);

      // R4: zero idle count acts as one
      tag = "R4";
      idle = 16'd0; rsel = 2'd3;
      req = 1; step(1);
      cmp("R4 listening", int'(initiator), 1);
      step(1);
      cmp("R4 field after one cycle", int'(rf_on), 1);
      cmp("R4 rate", int'(rate), 3);
      tend = 1; step(1); tend = 0; req = 0; step(3);

      // R8: withdrawal mid window
      tag = "R8";
      idle = 16'd6;
      req = 1; step(4); req = 0; step(1);
      cmp("R8 back to target", int'(initiator), 0);
      step(3);
      req = 1; step(5);
      cmp("R8 count restarted", int'(rf_on), 0);
      step(3);
      tend = 1; step(1); tend = 0; req = 0; step(2);

      // R3: detect held high blocks field indefinitely
      tag = "R3";
      idle = 16'd3; ext_field = 1; req = 1; step(15);
      cmp("R3 blocked by field", int'(rf_on), 0);
      ext_field = 0; step(8);
      cmp("R3 field after quiet", int'(rf_on), 1);
      tend = 1; step(1); tend = 0; req = 0; step(4);

      finish_run();
   end
endmodule